// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block divides the core clock down to the serial clock used by an SPI shift engine. It reads an 8-bit prescale setting. A static parameter selects how that setting is decoded. In the legacy decode the setting selects an even divider between 4 and 30. In the extended decode a 4-bit mantissa is multiplied by a power of two. The 3-bit exponent of that power is taken from two bit groups of the setting that are not next to each other, so dividers up to 1920 can be reached.

The block drives two outputs. The first is the serial clock level that the shift engine follows. The second is a one-cycle toggle strobe that warns the shift engine one core cycle before each edge of that clock. While the enable input is low the serial clock sits at its idle low level. When the prescale setting changes, the count for the current half-period starts again under the new setting.

Top module: `sclk_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk_phase` is 0 and `sclk_toggle` is 0.
- R2: When `clk_en` is low, `sclk_toggle` is 0 in that cycle and `sclk_phase` is 0 after the next clock edge. It stays 0 for as long as `clk_en` stays low.
- R3: With a divider N, one full `sclk_phase` period lasts N core cycles. The high phase lasts floor(N/2) cycles and the low phase lasts ceil(N/2) cycles. After `clk_en` rises, the first rising edge comes ceil(N/2) clock edges after the first edge at which `clk_en` is seen high.
- R4: Legacy decode (MODE = legacy). Let v = `prescale_cfg[4:0]`. For v from 18 to 31, N = 2*(v-16). For v below 18, N = 4. Bits [7:5] have no effect.
- R5: Extended decode. The mantissa M is `prescale_cfg[3:0]`. The exponent E is {`prescale_cfg[7]`, `prescale_cfg[6]`, `prescale_cfg[4]`}, with bit 4 as the least significant bit of E. N = M*2^E. Bit 5 has no effect.
- R6: Extended decode. A mantissa of 0 is used as 1. A product below 2 is raised to 2.
- R7: `sclk_toggle` is high for exactly one cycle before each change of `sclk_phase`. That gives two strobes per period. It is never high while `clk_en` is low, and `sclk_phase` never changes while `clk_en` is high without a strobe.
- R8: In a cycle where `prescale_cfg` differs from its value at the previous edge, `sclk_toggle` is 0. The current half-period then restarts from zero under the new divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Runs the divider when high; holds the serial clock idle low when low |
| prescale_cfg | input | 8 | Prescale setting, decoded according to MODE |
| sclk_toggle | output | 1 | One-cycle strobe in the cycle before each serial clock edge |
| sclk_phase | output | 1 | Serial clock level for the shift engine |

## Verification
On every cycle the assertions check the following:
- The idle level while `clk_en` is low.
- That each strobe is followed by a serial clock edge, and that no edge happens without a strobe.
- That no strobe appears in a cycle where the setting has just changed.
- That no half-period runs past the longest one the chosen decode allows.

Three things can only be shown by the bench scenarios. The first is the exact half-period lengths for each encoding, including the floor/ceiling split for odd dividers. The second is the decode arithmetic, including the split exponent bits, the zero-mantissa case, the legacy clamp, and the ignored bits. The third is the cycle at which the serial clock settles after a setting change mid-period or after `clk_en` rises.

// File: rtl/presc_pkg.sv
package presc_pkg;
   typedef enum logic {
      PRESC_LEGACY   = 1'b0,
      PRESC_EXTENDED = 1'b1
   } presc_mode_e;

   // Bit positions the extended decode depends on
   localparam int EXP_LSB_POS    = 4;
   localparam int EXP_HI_LSB_POS = 6;
   localparam int EXP_HI_W       = 2;
   localparam int CFG_FIELD_W    = 8;
endpackage

// File: rtl/presc_decode.sv
module presc_decode
   import presc_pkg::*;
#(
   parameter presc_mode_e MODE = PRESC_EXTENDED,
   parameter int FIELD_W       = 8,
   parameter int MANT_W        = 4,
   parameter int EXP_W         = 3,
   parameter int LEG_W         = 5,
   parameter int LEG_BASE      = 16,
   parameter int LEG_MIN_DIV   = 4,
   parameter int DIV_W         = 11
) (
   input  logic [FIELD_W-1:0] cfg,
   output logic [DIV_W-1:0]   divider
);
   localparam int LEG_MIN_FIELD = LEG_BASE + LEG_MIN_DIV / 2;

   generate
      if (MODE == PRESC_EXTENDED) begin : g_ext
         logic [MANT_W-1:0] mant;
         logic [MANT_W-1:0] mant_eff;
         logic [EXP_W-1:0]  expo;
         logic [DIV_W-1:0]  prod;

         assign mant     = cfg[MANT_W-1:0];
         assign mant_eff = (mant == '0) ? MANT_W'(1) : mant;
         assign expo     = {cfg[EXP_HI_LSB_POS +: EXP_HI_W], cfg[EXP_LSB_POS]};
         assign prod     = DIV_W'(mant_eff) << expo;

         always_comb begin
            if (prod < DIV_W'(2)) divider = DIV_W'(2);
            else                  divider = prod;
         end
      end else begin : g_leg
         logic [LEG_W-1:0] lv;
         assign lv = cfg[LEG_W-1:0];

         always_comb begin
            if (int'(lv) < LEG_MIN_FIELD)
               divider = DIV_W'(LEG_MIN_DIV);
            else
               divider = (DIV_W'(lv) - DIV_W'(LEG_BASE)) << 1;
         end
      end
   endgenerate
endmodule

// File: rtl/presc_halves.sv
module presc_halves #(
   parameter int DIV_W  = 11,
   parameter int HALF_W = 11
) (
   input  logic [DIV_W-1:0]  divider,
   output logic [HALF_W-1:0] len_low,
   output logic [HALF_W-1:0] len_high
);
   logic [DIV_W:0] rounded;

   assign rounded  = {1'b0, divider} + {{DIV_W{1'b0}}, 1'b1};
   assign len_low  = HALF_W'(rounded >> 1);
   assign len_high = HALF_W'({1'b0, divider} >> 1);
endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
   parameter int FIELD_W = 8,
   parameter int HALF_W  = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic [FIELD_W-1:0] cfg,
   input  logic [HALF_W-1:0]  len_low,
   input  logic [HALF_W-1:0]  len_high,
   output logic               strobe,
   output logic               level
);
   logic [HALF_W-1:0]  cnt_q;
   logic [FIELD_W-1:0] cfg_q;
   logic [HALF_W-1:0]  cur_len;
   logic               cfg_moved;

   assign cur_len   = level ? len_high : len_low;
   assign cfg_moved = (cfg_q != cfg);
   assign strobe    = clk_en && !cfg_moved && (cnt_q == cur_len - HALF_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cfg_q <= '0;
         level <= 1'b0;
      end else begin
         cfg_q <= cfg;
         if (!clk_en) begin
            cnt_q <= '0;
            level <= 1'b0;
         end else if (cfg_moved) begin
            cnt_q <= '0;
         end else if (strobe) begin
            cnt_q <= '0;
            level <= ~level;
         end else begin
            cnt_q <= cnt_q + HALF_W'(1);
         end
      end
   end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
   import presc_pkg::*;
#(
   parameter presc_mode_e MODE = PRESC_EXTENDED,
   parameter int FIELD_W       = 8,
   parameter int MANT_W        = 4,
   parameter int EXP_W         = 3,
   parameter int LEG_W         = 5,
   parameter int LEG_BASE      = 16,
   parameter int LEG_MIN_DIV   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic [FIELD_W-1:0] prescale_cfg,
   output logic               sclk_toggle,
   output logic               sclk_phase
);
   localparam int DIV_W    = (MODE == PRESC_EXTENDED) ? (MANT_W + (1 << EXP_W) - 1) : (LEG_W + 1);
   localparam int HALF_W   = DIV_W;
   localparam int MAX_DIV  = (MODE == PRESC_EXTENDED)
                           ? (((1 << MANT_W) - 1) << ((1 << EXP_W) - 1))
                           : (2 * ((1 << LEG_W) - 1 - LEG_BASE));
   localparam int MAX_HALF = (MAX_DIV + 1) / 2;

   // Elaboration-time parameter checks
   if (FIELD_W != CFG_FIELD_W) begin : g_bad_field
      $error("sclk_prescaler: FIELD_W must be %0d", CFG_FIELD_W);
   end
   if (MODE == PRESC_EXTENDED && (MANT_W != EXP_LSB_POS || EXP_W != EXP_HI_W + 1)) begin : g_bad_ext
      $error("sclk_prescaler: extended decode needs MANT_W=4 and EXP_W=3");
   end
   if (MODE == PRESC_LEGACY && (LEG_W > FIELD_W || LEG_MIN_DIV < 2 || LEG_BASE + LEG_MIN_DIV / 2 >= (1 << LEG_W))) begin : g_bad_leg
      $error("sclk_prescaler: inconsistent legacy parameters");
   end

   logic [DIV_W-1:0]  divider;
   logic [HALF_W-1:0] len_low;
   logic [HALF_W-1:0] len_high;

   presc_decode #(
      .MODE(MODE), .FIELD_W(FIELD_W), .MANT_W(MANT_W), .EXP_W(EXP_W),
      .LEG_W(LEG_W), .LEG_BASE(LEG_BASE), .LEG_MIN_DIV(LEG_MIN_DIV), .DIV_W(DIV_W)
   ) u_decode (
      .cfg     (prescale_cfg),
      .divider (divider)
   );

   presc_halves #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_halves (
      .divider  (divider),
      .len_low  (len_low),
      .len_high (len_high)
   );

   presc_counter #(.FIELD_W(FIELD_W), .HALF_W(HALF_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .cfg      (prescale_cfg),
      .len_low  (len_low),
      .len_high (len_high),
      .strobe   (sclk_toggle),
      .level    (sclk_phase)
   );
endmodule

// File: rtl/presc_chk.sv
module presc_chk #(
   parameter int FIELD_W  = 8,
   parameter int MAX_HALF = 960
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clk_en,
   input logic [FIELD_W-1:0] prescale_cfg,
   input logic               sclk_toggle,
   input logic               sclk_phase
);
   int unsigned        run_q;
   logic [FIELD_W-1:0] prev_cfg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 0;
         prev_cfg <= '0;
      end else begin
         prev_cfg <= prescale_cfg;
         if (!clk_en || sclk_toggle || prev_cfg != prescale_cfg) run_q <= 0;
         else                                                    run_q <= run_q + 1;
      end
   end

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> !sclk_phase);                                             // R2
   AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_toggle |-> clk_en);                                              // R7
   AST_STROBE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_toggle |=> (sclk_phase != $past(sclk_phase)));                   // R7
   AST_NO_SILENT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !sclk_toggle) |=> $stable(sclk_phase));                    // R7
   AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (prescale_cfg != $past(prescale_cfg)) |-> !sclk_toggle);              // R8
   AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= MAX_HALF);                                                   // R3
endmodule

bind sclk_prescaler presc_chk #(.FIELD_W(FIELD_W), .MAX_HALF(MAX_HALF)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clk_en       (clk_en),
   .prescale_cfg (prescale_cfg),
   .sclk_toggle  (sclk_toggle),
   .sclk_phase   (sclk_phase)
);

// File: tb/sclk_prescaler_tb.sv
module sclk_prescaler_tb;
   import presc_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_e = 1'b0, en_l = 1'b0;
   logic [7:0] cfg_e = 8'h00, cfg_l = 8'h00;
   logic       tg_e, ph_e, tg_l, ph_l;
   int         n_checks = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sclk_prescaler #(.MODE(PRESC_EXTENDED)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(en_e), .prescale_cfg(cfg_e),
      .sclk_toggle(tg_e), .sclk_phase(ph_e));

   sclk_prescaler #(.MODE(PRESC_LEGACY)) u_dut_leg (
      .clk(clk), .rst_n(rst_n), .clk_en(en_l), .prescale_cfg(cfg_l),
      .sclk_toggle(tg_l), .sclk_phase(ph_l));

   function automatic int exp_leg(int f);
      int v = f & 31;
      if (v < 18) return 4;
      return 2 * (v - 16);
   endfunction

   function automatic int exp_ext(int f);
      int m = f & 15;
      int e = ((f >> 4) & 1) | (((f >> 6) & 3) << 1);
      int n;
      if (m == 0) m = 1;
      n = m << e;
      if (n < 2) n = 2;
      return n;
   endfunction

   function automatic bit cur_ph(bit ext);
      return ext ? ph_e : ph_l;
   endfunction

   function automatic bit cur_tg(bit ext);
      return ext ? tg_e : tg_l;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic measure(bit ext, output int hi, output int lo, output int tk);
      int guard = 0;
      hi = 0; lo = 0; tk = 0;
      while (cur_ph(ext) == 1'b1 && guard < 10000) begin step(); guard++; end
      while (cur_ph(ext) == 1'b0 && guard < 10000) begin step(); guard++; end
      while (cur_ph(ext) == 1'b1 && guard < 10000) begin
         hi++; if (cur_tg(ext)) tk++; step(); guard++;
      end
      while (cur_ph(ext) == 1'b0 && guard < 10000) begin
         lo++; if (cur_tg(ext)) tk++; step(); guard++;
      end
   endtask

   task automatic run_case(bit ext, int f, string req);
      int n, hi, lo, tk;
      @(negedge clk);
      if (ext) cfg_e = 8'(f); else cfg_l = 8'(f);
      #1;
      n = ext ? exp_ext(f) : exp_leg(f);
      measure(ext, hi, lo, tk);
      check(hi == n / 2, {req, " R3 high phase"}, hi, n / 2);
      check(lo == (n + 1) / 2, {req, " R3 low phase"}, lo, (n + 1) / 2);
      check(tk == 2, "R7 strobes per period", tk, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) step();
      check(ph_e == 0 && ph_l == 0, "R1 phase in reset", int'(ph_e | ph_l), 0);
      check(tg_e == 0 && tg_l == 0, "R1 strobe in reset", int'(tg_e | tg_l), 0);
      @(negedge clk); rst_n = 1'b1; #1;
      step();
      check(ph_e == 0 && ph_l == 0, "R1 phase after reset", int'(ph_e | ph_l), 0);

      @(negedge clk); en_e = 1'b1; en_l = 1'b1;

      // R4 legacy sweep, upper bits varied to show they are ignored
      for (int v = 0; v < 32; v++) run_case(1'b0, v | ((v % 8) << 5), "R4");

      // R5 R6 extended sweep over low exponents, bit 5 included
      for (int f = 0; f < 128; f++) run_case(1'b1, f, "R5 R6");
      // R5 high exponent bits [7:6]
      run_case(1'b1, 8'h81, "R5 exp4");
      run_case(1'b1, 8'hC0, "R6 zero mantissa exp6");
      run_case(1'b1, 8'hD5, "R5 exp7");
      run_case(1'b1, 8'hFF, "R5 max");
      run_case(1'b1, 8'hEF, "R5 bit5 ignored");

      // R8 setting change mid half-period (legacy 30 -> 4)
      run_case(1'b0, 8'h1F, "R8 setup");
      while (ph_l != 1'b1) step();
      repeat (5) step();
      @(negedge clk); cfg_l = 8'h12; #1;
      check(tg_l == 0, "R8 strobe on change", int'(tg_l), 0);
      step();
      check(ph_l == 1, "R8 held after change", int'(ph_l), 1);
      step();
      check(tg_l == 1 && ph_l == 1, "R8 strobe at new length", int'(tg_l), 1);
      step();
      check(ph_l == 0, "R8 edge at new length", int'(ph_l), 0);

      // R2 disable, R3 first edge after enable
      @(negedge clk); cfg_l = 8'h13; #1;
      repeat (4) step();
      @(negedge clk); en_l = 1'b0; #1;
      check(tg_l == 0, "R2 strobe when disabled", int'(tg_l), 0);
      for (int i = 0; i < 6; i++) begin
         step();
         check(ph_l == 0 && tg_l == 0, "R2 idle low", int'(ph_l | tg_l), 0);
      end
      @(negedge clk); en_l = 1'b1; #1;
      step(); step();
      check(ph_l == 0, "R3 before first rise", int'(ph_l), 0);
      step();
      check(ph_l == 1, "R3 first rise at ceil(N/2)", int'(ph_l), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule